// File: doc/BRIEF.md
# I2C Byte-Event Interrupt and Clock-Stretch Controller

This block runs next to an I2C bit engine, in the system clock domain. The engine reports each detected SCL falling edge, the start and stop conditions it sees, the phase of the current byte and the result of the slave address compare. From these inputs the block decides whether a byte raises an interrupt and whether SCL is held low, and if so on which falling edge, the 8th or the 9th of the byte. The answer depends on the role (master or slave), the byte phase, the address match, extension-code detection, restart history and a timing-select bit. The block drives a one-cycle interrupt pulse, a level request that tells the engine to keep SCL low, and a flag that forces an ACK on a matched slave address.

A control state machine has four states. IDLE waits for a start condition. BITS counts falling edges and checks each one against the planned event point. HOLD keeps SCL low until a release strobe arrives. SKIP ignores the rest of a transfer addressed to another device. The transitions are as follows.
- IDLE→BITS on a start.
- BITS→HOLD on an event that stretches the clock.
- BITS→SKIP on an unmatched address.
- HOLD→BITS on a release.
- Any state→BITS on a start.
- Any state→IDLE on a stop.

The byte counter clears on every start or stop condition. It counts falling edges 1 to 9, then wraps back to 1.

Top module: `i2c_stretch_ctrl`

## Requirements
- R1: During reset and directly after it, `byte_irq`, `scl_hold_low` and `ack_force` are all 0 and the controller is idle.
- R2: In a data byte (`byte_phase` 2'b01 receive or 2'b10 transmit, 2'b11 treated as data), in either role, the controller reacts to `late_event_sel`. With 0, it pulses `byte_irq` and raises `scl_hold_low` one cycle after the 8th falling edge. With 1, it does both one cycle after the 9th falling edge.
- R3: For an address byte (`byte_phase` 2'b00) in master role (`is_master`=1), the interrupt and the hold come after the 9th falling edge, whatever `late_event_sel` is.
- R4: For a slave address byte with `own_addr_hit`=1, the interrupt and the hold come after the 9th falling edge, whatever `late_event_sel` is. `ack_force` is 1 from the cycle after the 8th falling edge until the cycle after the 9th falling edge.
- R5: For a slave address byte with `own_addr_hit`=0 and `ext_code_hit`=1, the interrupt and the hold come after the 8th falling edge.
- R6: For a slave address byte with no match, no extension code and `after_restart`=1, `byte_irq` pulses after the 9th falling edge and `scl_hold_low` stays 0. Later bytes of that transfer raise nothing.
- R7: For a slave address byte with no match, no extension code and no restart, nothing is raised. Every later byte is ignored until the next start or stop.
- R8: A hold is released in the cycle after `rel_shift_wr` or `rel_wait_cmd`. In master role, `rel_start_cmd` or `rel_stop_cmd` also releases it. In slave role, those two commands leave the hold in place. Falling edges seen during a hold are not counted.
- R9: Release strobes given while no hold is active change none of the outputs.
- R10: `stop_seen` pulses `byte_irq` in the next cycle only if `stop_irq_en`=1. It also clears the hold and `ack_force`, returns the controller to idle, and takes priority over a release strobe in the same cycle.
- R11: `start_seen` clears the byte counter. It takes priority over `scl_fall` in the same cycle.
- R12: `byte_irq` is a one-cycle pulse. Falling edges seen before the first start raise nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| byte_phase | input | 2 | 00 address, 01 data receive, 10 data transmit |
| own_addr_hit | input | 1 | Received address equals own slave address |
| ext_code_hit | input | 1 | Received address is an extension code |
| after_restart | input | 1 | Current address byte followed a repeated start |
| scl_fall | input | 1 | One-cycle pulse per detected SCL falling edge |
| start_seen | input | 1 | Start or repeated-start detected pulse |
| stop_seen | input | 1 | Stop detected pulse |
| stop_irq_en | input | 1 | Enables the interrupt on a stop |
| late_event_sel | input | 1 | Data-byte event point: 0 = 8th edge, 1 = 9th edge |
| rel_shift_wr | input | 1 | Shift-register write strobe (releases hold) |
| rel_wait_cmd | input | 1 | Wait-release command strobe |
| rel_start_cmd | input | 1 | Start-generation command strobe |
| rel_stop_cmd | input | 1 | Stop-generation command strobe |
| byte_irq | output | 1 | Byte-event / stop interrupt pulse |
| scl_hold_low | output | 1 | Request to keep SCL low |
| ack_force | output | 1 | Force ACK on the matched slave address |

## Verification
Two functions can fall in the same cycle. A stop condition can arrive in the same cycle as a release strobe while the clock is held. A start condition can also arrive together with an SCL falling-edge pulse. The bench drives both collisions on purpose. In the first case it expects the stop to win: the hold drops, and the interrupt follows only the stop-enable bit. In the second case it expects the start to clear the count, so that the matched-address ACK flag and the interrupt land on the 8th and 9th edges counted from that start. A behavioural model in the bench is compared against the outputs on every clock.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [1:0] {
        PH_ADDR = 2'b00,
        PH_RX   = 2'b01,
        PH_TX   = 2'b10,
        PH_RSVD = 2'b11
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BITS,
        ST_HOLD,
        ST_SKIP
    } ctl_state_e;

    // What the current byte asks for at its event point.
    typedef struct packed {
        logic fire;      // pulse the interrupt
        logic stretch;   // hold SCL low afterwards
        logic skip;      // ignore the rest of the transfer
        logic ack_addr;  // force ACK on this address
    } plan_t;

endpackage

// File: rtl/i2cs_bit_counter.sv
module i2cs_bit_counter #(
    parameter int BYTE_BITS = 8,
    parameter int CNT_W     = $clog2(BYTE_BITS + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_next
);
    localparam int LAST = BYTE_BITS + 1;

    // Value the counter takes on the next falling edge: 1..LAST, wrapping.
    always_comb begin
        if (count == CNT_W'(LAST)) begin
            count_next = CNT_W'(1);
        end else begin
            count_next = count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (advance) begin
            count <= count_next;
        end
    end

endmodule

// File: rtl/i2cs_event_plan.sv
module i2cs_event_plan
    import i2cs_pkg::*;
#(
    parameter int BYTE_BITS = 8,
    parameter int CNT_W     = $clog2(BYTE_BITS + 2)
) (
    input  logic             is_master,
    input  logic [1:0]       byte_phase,
    input  logic             own_addr_hit,
    input  logic             ext_code_hit,
    input  logic             after_restart,
    input  logic             late_event_sel,
    output logic [CNT_W-1:0] point,
    output plan_t            plan
);
    localparam logic [CNT_W-1:0] EP_EARLY = CNT_W'(BYTE_BITS);
    localparam logic [CNT_W-1:0] EP_LATE  = CNT_W'(BYTE_BITS + 1);

    always_comb begin
        point = EP_LATE;
        plan  = '0;
        if (byte_phase == PH_ADDR) begin
            if (is_master) begin
                plan.fire    = 1'b1;
                plan.stretch = 1'b1;
            end else if (own_addr_hit) begin
                plan.fire     = 1'b1;
                plan.stretch  = 1'b1;
                plan.ack_addr = 1'b1;
            end else if (ext_code_hit) begin
                point        = EP_EARLY;
                plan.fire    = 1'b1;
                plan.stretch = 1'b1;
            end else if (after_restart) begin
                plan.fire = 1'b1;
                plan.skip = 1'b1;
            end else begin
                plan.skip = 1'b1;
            end
        end else begin
            point        = late_event_sel ? EP_LATE : EP_EARLY;
            plan.fire    = 1'b1;
            plan.stretch = 1'b1;
        end
    end

endmodule

// File: rtl/i2cs_ctrl_fsm.sv
module i2cs_ctrl_fsm
    import i2cs_pkg::*;
#(
    parameter int BYTE_BITS = 8,
    parameter int CNT_W     = $clog2(BYTE_BITS + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_master,
    input  logic             scl_fall,
    input  logic             start_seen,
    input  logic             stop_seen,
    input  logic             stop_irq_en,
    input  logic             rel_shift_wr,
    input  logic             rel_wait_cmd,
    input  logic             rel_start_cmd,
    input  logic             rel_stop_cmd,
    input  logic [CNT_W-1:0] count_next,
    input  logic [CNT_W-1:0] point,
    input  plan_t            plan,
    output logic             cnt_clear,
    output logic             cnt_advance,
    output logic             byte_irq,
    output logic             scl_hold_low,
    output logic             ack_force
);
    localparam logic [CNT_W-1:0] EP_EARLY = CNT_W'(BYTE_BITS);

    ctl_state_e state_q, state_d;
    logic       at_event;
    logic       released;
    logic       bus_cond;

    assign bus_cond = start_seen | stop_seen;
    assign at_event = scl_fall && (count_next == point);
    assign released = rel_shift_wr | rel_wait_cmd |
                      (is_master & (rel_start_cmd | rel_stop_cmd));

    assign cnt_clear   = bus_cond;
    assign cnt_advance = scl_fall && !bus_cond && (state_q != ST_HOLD);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_seen && !stop_seen) state_d = ST_BITS;
            end
            ST_BITS: begin
                if (stop_seen)       state_d = ST_IDLE;
                else if (start_seen) state_d = ST_BITS;
                else if (at_event && plan.stretch) state_d = ST_HOLD;
                else if (at_event && plan.skip)    state_d = ST_SKIP;
            end
            ST_HOLD: begin
                if (stop_seen)       state_d = ST_IDLE;
                else if (start_seen) state_d = ST_BITS;
                else if (released)   state_d = ST_BITS;
            end
            ST_SKIP: begin
                if (stop_seen)       state_d = ST_IDLE;
                else if (start_seen) state_d = ST_BITS;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_irq  <= 1'b0;
            ack_force <= 1'b0;
        end else begin
            byte_irq <= (stop_seen & stop_irq_en) |
                        (!bus_cond && (state_q == ST_BITS) && at_event && plan.fire);
            if (bus_cond) begin
                ack_force <= 1'b0;
            end else if ((state_q == ST_BITS) && scl_fall) begin
                ack_force <= plan.ack_addr && (count_next == EP_EARLY);
            end
        end
    end

    assign scl_hold_low = (state_q == ST_HOLD);

endmodule

// File: rtl/i2c_stretch_ctrl.sv
module i2c_stretch_ctrl
    import i2cs_pkg::*;
#(
    parameter int BYTE_BITS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       is_master,
    input  logic [1:0] byte_phase,
    input  logic       own_addr_hit,
    input  logic       ext_code_hit,
    input  logic       after_restart,
    input  logic       scl_fall,
    input  logic       start_seen,
    input  logic       stop_seen,
    input  logic       stop_irq_en,
    input  logic       late_event_sel,
    input  logic       rel_shift_wr,
    input  logic       rel_wait_cmd,
    input  logic       rel_start_cmd,
    input  logic       rel_stop_cmd,
    output logic       byte_irq,
    output logic       scl_hold_low,
    output logic       ack_force
);
    localparam int CNT_W = $clog2(BYTE_BITS + 2);

    logic             cnt_clear;
    logic             cnt_advance;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] count_next;
    logic [CNT_W-1:0] point;
    plan_t            plan;

    i2cs_bit_counter #(
        .BYTE_BITS (BYTE_BITS),
        .CNT_W     (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (cnt_clear),
        .advance    (cnt_advance),
        .count      (count),
        .count_next (count_next)
    );

    i2cs_event_plan #(
        .BYTE_BITS (BYTE_BITS),
        .CNT_W     (CNT_W)
    ) u_plan (
        .is_master      (is_master),
        .byte_phase     (byte_phase),
        .own_addr_hit   (own_addr_hit),
        .ext_code_hit   (ext_code_hit),
        .after_restart  (after_restart),
        .late_event_sel (late_event_sel),
        .point          (point),
        .plan           (plan)
    );

    i2cs_ctrl_fsm #(
        .BYTE_BITS (BYTE_BITS),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .is_master     (is_master),
        .scl_fall      (scl_fall),
        .start_seen    (start_seen),
        .stop_seen     (stop_seen),
        .stop_irq_en   (stop_irq_en),
        .rel_shift_wr  (rel_shift_wr),
        .rel_wait_cmd  (rel_wait_cmd),
        .rel_start_cmd (rel_start_cmd),
        .rel_stop_cmd  (rel_stop_cmd),
        .count_next    (count_next),
        .point         (point),
        .plan          (plan),
        .cnt_clear     (cnt_clear),
        .cnt_advance   (cnt_advance),
        .byte_irq      (byte_irq),
        .scl_hold_low  (scl_hold_low),
        .ack_force     (ack_force)
    );

    logic unused_count;
    assign unused_count = ^count;

endmodule

// File: rtl/i2cs_ctrl_chk.sv
module i2cs_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic is_master,
    input logic scl_fall,
    input logic start_seen,
    input logic stop_seen,
    input logic stop_irq_en,
    input logic rel_shift_wr,
    input logic rel_wait_cmd,
    input logic byte_irq,
    input logic scl_hold_low,
    input logic ack_force
);

    p_irq_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_irq && !stop_seen && !scl_fall) |=> !byte_irq);

    p_irq_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
        byte_irq |-> $past(scl_fall || stop_seen));

    p_stop_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_seen && stop_irq_en) |=> byte_irq);

    p_stop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> (!scl_hold_low && !ack_force));

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hold_low && (rel_shift_wr || rel_wait_cmd)) |=> !scl_hold_low);

    p_slave_keeps_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hold_low && !is_master && !rel_shift_wr && !rel_wait_cmd &&
         !start_seen && !stop_seen) |=> scl_hold_low);

    p_hold_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_hold_low) |-> $past(scl_fall));

endmodule

bind i2c_stretch_ctrl i2cs_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .is_master    (is_master),
    .scl_fall     (scl_fall),
    .start_seen   (start_seen),
    .stop_seen    (stop_seen),
    .stop_irq_en  (stop_irq_en),
    .rel_shift_wr (rel_shift_wr),
    .rel_wait_cmd (rel_wait_cmd),
    .byte_irq     (byte_irq),
    .scl_hold_low (scl_hold_low),
    .ack_force    (ack_force)
);

// File: tb/i2c_stretch_ctrl_tb.sv
`timescale 1ns/1ps
module i2c_stretch_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       is_master = 1'b0;
    logic [1:0] byte_phase = 2'b00;
    logic       own_addr_hit = 1'b0;
    logic       ext_code_hit = 1'b0;
    logic       after_restart = 1'b0;
    logic       scl_fall = 1'b0;
    logic       start_seen = 1'b0;
    logic       stop_seen = 1'b0;
    logic       stop_irq_en = 1'b0;
    logic       late_event_sel = 1'b0;
    logic       rel_shift_wr = 1'b0;
    logic       rel_wait_cmd = 1'b0;
    logic       rel_start_cmd = 1'b0;
    logic       rel_stop_cmd = 1'b0;
    logic       byte_irq;
    logic       scl_hold_low;
    logic       ack_force;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    i2c_stretch_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .byte_phase(byte_phase),
        .own_addr_hit(own_addr_hit), .ext_code_hit(ext_code_hit),
        .after_restart(after_restart), .scl_fall(scl_fall),
        .start_seen(start_seen), .stop_seen(stop_seen), .stop_irq_en(stop_irq_en),
        .late_event_sel(late_event_sel), .rel_shift_wr(rel_shift_wr),
        .rel_wait_cmd(rel_wait_cmd), .rel_start_cmd(rel_start_cmd),
        .rel_stop_cmd(rel_stop_cmd), .byte_irq(byte_irq),
        .scl_hold_low(scl_hold_low), .ack_force(ack_force)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Behavioural reference: mode 0 idle, 1 counting, 2 held, 3 ignoring
    int m_mode = 0;
    int m_cnt  = 0;
    bit m_irq  = 0;
    bit m_ack  = 0;

    always @(posedge clk) begin
        int at; bit ev_irq; bit ev_wait; bit ev_skip;
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_irq = 0; m_ack = 0;
        end else begin
            m_irq = 0;
            if (stop_seen) begin
                m_irq = stop_irq_en; m_mode = 0; m_cnt = 0; m_ack = 0;
            end else if (start_seen) begin
                m_mode = 1; m_cnt = 0; m_ack = 0;
            end else if (m_mode == 2) begin
                if (rel_shift_wr || rel_wait_cmd ||
                    (is_master && (rel_start_cmd || rel_stop_cmd))) m_mode = 1;
            end else if (scl_fall) begin
                m_cnt = (m_cnt == 9) ? 1 : m_cnt + 1;
                if (m_mode == 1) begin
                    m_ack = !is_master && byte_phase == 2'b00 && own_addr_hit && m_cnt == 8;
                    at = 9; ev_irq = 1; ev_wait = 1; ev_skip = 0;
                    if (byte_phase != 2'b00) at = late_event_sel ? 9 : 8;
                    else if (is_master || own_addr_hit) at = 9;
                    else if (ext_code_hit) at = 8;
                    else if (after_restart) begin ev_wait = 0; ev_skip = 1; end
                    else begin ev_irq = 0; ev_wait = 0; ev_skip = 1; end
                    if (m_cnt == at) begin
                        m_irq = ev_irq;
                        if (ev_wait) m_mode = 2;
                        else if (ev_skip) m_mode = 3;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("MODEL irq", byte_irq, m_irq);
            chk("MODEL hold", scl_hold_low, m_mode == 2);
            chk("MODEL ack", ack_force, m_ack);
        end
    end

    task automatic fall();
        scl_fall = 1'b1;
        @(negedge clk);
        scl_fall = 1'b0;
    endtask

    task automatic falls(input int n);
        for (int i = 0; i < n; i++) begin
            fall();
            @(negedge clk);
        end
    endtask

    task automatic start_pulse();
        start_seen = 1'b1;
        @(negedge clk);
        start_seen = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", byte_irq, 1'b0);
        chk("R1 hold in reset", scl_hold_low, 1'b0);
        chk("R1 ack in reset", ack_force, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 hold after reset", scl_hold_low, 1'b0);

        // R12: edges before any start raise nothing
        byte_phase = 2'b01; late_event_sel = 1'b0;
        falls(7); fall();
        chk("R12 idle 8th irq", byte_irq, 1'b0);
        chk("R12 idle 8th hold", scl_hold_low, 1'b0);
        @(negedge clk);

        // R9: strobes with no hold
        is_master = 1'b1;
        rel_shift_wr = 1; rel_wait_cmd = 1; rel_start_cmd = 1; rel_stop_cmd = 1;
        @(negedge clk);
        rel_shift_wr = 0; rel_wait_cmd = 0; rel_start_cmd = 0; rel_stop_cmd = 0;
        chk("R9 idle strobes hold", scl_hold_low, 1'b0);
        chk("R9 idle strobes irq", byte_irq, 1'b0);

        // R3: master address, select 0
        start_pulse();
        byte_phase = 2'b00;
        falls(7); fall();
        chk("R3 master addr 8th irq", byte_irq, 1'b0);
        @(negedge clk);
        fall();
        chk("R3 master addr 9th irq", byte_irq, 1'b1);
        chk("R3 master addr 9th hold", scl_hold_low, 1'b1);
        @(negedge clk);
        chk("R12 pulse width", byte_irq, 1'b0);
        chk("R8 hold kept", scl_hold_low, 1'b1);
        rel_wait_cmd = 1; @(negedge clk); rel_wait_cmd = 0;
        chk("R8 wait cmd release", scl_hold_low, 1'b0);
        rel_shift_wr = 1; @(negedge clk); rel_shift_wr = 0;
        chk("R9 strobe no hold", scl_hold_low, 1'b0);
        chk("R9 strobe no irq", byte_irq, 1'b0);

        // R2: master receive, select 0
        byte_phase = 2'b01;
        falls(7); fall();
        chk("R2 rx early irq", byte_irq, 1'b1);
        chk("R2 rx early hold", scl_hold_low, 1'b1);
        @(negedge clk);
        fall();
        chk("R8 edge in hold keeps hold", scl_hold_low, 1'b1);
        @(negedge clk);
        rel_start_cmd = 1; @(negedge clk); rel_start_cmd = 0;
        chk("R8 master start cmd release", scl_hold_low, 1'b0);
        fall();
        chk("R2 rx 9th no irq", byte_irq, 1'b0);
        @(negedge clk);

        // R2: master transmit, select 1
        byte_phase = 2'b10; late_event_sel = 1'b1;
        falls(7); fall();
        chk("R2 tx 8th no irq", byte_irq, 1'b0);
        @(negedge clk);
        fall();
        chk("R2 tx late irq", byte_irq, 1'b1);
        chk("R2 tx late hold", scl_hold_low, 1'b1);
        @(negedge clk);
        rel_stop_cmd = 1; @(negedge clk); rel_stop_cmd = 0;
        chk("R8 master stop cmd release", scl_hold_low, 1'b0);

        // R10: stop with interrupt enabled
        stop_irq_en = 1'b1;
        stop_seen = 1; @(negedge clk); stop_seen = 0;
        chk("R10 stop irq", byte_irq, 1'b1);
        @(negedge clk);
        chk("R12 stop pulse width", byte_irq, 1'b0);

        // R4: slave matched address, select 0
        start_pulse();
        is_master = 1'b0; byte_phase = 2'b00; late_event_sel = 1'b0; own_addr_hit = 1'b1;
        falls(7); fall();
        chk("R4 ack after 8th", ack_force, 1'b1);
        chk("R4 no irq at 8th", byte_irq, 1'b0);
        @(negedge clk);
        fall();
        chk("R4 irq at 9th", byte_irq, 1'b1);
        chk("R4 hold at 9th", scl_hold_low, 1'b1);
        chk("R4 ack dropped", ack_force, 1'b0);
        @(negedge clk);
        rel_start_cmd = 1; rel_stop_cmd = 1; @(negedge clk);
        rel_start_cmd = 0; rel_stop_cmd = 0;
        chk("R8 slave commands keep hold", scl_hold_low, 1'b1);
        rel_shift_wr = 1; @(negedge clk); rel_shift_wr = 0;
        chk("R8 shift write release", scl_hold_low, 1'b0);

        // R2: slave receive, select 1
        own_addr_hit = 1'b0; byte_phase = 2'b01; late_event_sel = 1'b1;
        falls(8); fall();
        chk("R2 slave rx late irq", byte_irq, 1'b1);
        chk("R2 slave rx late hold", scl_hold_low, 1'b1);
        @(negedge clk);

        // R10: stop collides with release, interrupt disabled
        stop_irq_en = 1'b0;
        stop_seen = 1; rel_wait_cmd = 1; @(negedge clk);
        stop_seen = 0; rel_wait_cmd = 0;
        chk("R10 stop no irq when disabled", byte_irq, 1'b0);
        chk("R10 stop drops hold", scl_hold_low, 1'b0);

        // R5: extension code
        start_pulse();
        byte_phase = 2'b00; ext_code_hit = 1'b1;
        falls(7); fall();
        chk("R5 ext irq at 8th", byte_irq, 1'b1);
        chk("R5 ext hold at 8th", scl_hold_low, 1'b1);
        @(negedge clk);
        rel_wait_cmd = 1; @(negedge clk); rel_wait_cmd = 0;
        fall();
        chk("R5 ext no irq at 9th", byte_irq, 1'b0);
        @(negedge clk);
        ext_code_hit = 1'b0;

        // R6: no match after repeated start
        after_restart = 1'b1;
        start_pulse();
        falls(8); fall();
        chk("R6 restart irq at 9th", byte_irq, 1'b1);
        chk("R6 restart no hold", scl_hold_low, 1'b0);
        @(negedge clk);
        after_restart = 1'b0; byte_phase = 2'b01; late_event_sel = 1'b0;
        falls(7); fall();
        chk("R6 following byte ignored", byte_irq, 1'b0);
        chk("R6 following byte no hold", scl_hold_low, 1'b0);
        @(negedge clk);

        // R7: no match, no restart
        start_pulse();
        byte_phase = 2'b00;
        falls(8); fall();
        chk("R7 no irq", byte_irq, 1'b0);
        chk("R7 no hold", scl_hold_low, 1'b0);
        @(negedge clk);
        byte_phase = 2'b10;
        falls(7); fall();
        chk("R7 data ignored irq", byte_irq, 1'b0);
        chk("R7 data ignored hold", scl_hold_low, 1'b0);
        @(negedge clk);
        stop_irq_en = 1'b1;
        stop_seen = 1; @(negedge clk); stop_seen = 0;
        chk("R10 stop irq after skip", byte_irq, 1'b1);

        // R11: start together with an edge restarts the count
        start_pulse();
        byte_phase = 2'b00; own_addr_hit = 1'b1;
        falls(5);
        start_seen = 1; scl_fall = 1; @(negedge clk);
        start_seen = 0; scl_fall = 0;
        @(negedge clk);
        falls(7); fall();
        chk("R11 ack at 8th from start", ack_force, 1'b1);
        chk("R11 no irq at 8th", byte_irq, 1'b0);
        @(negedge clk);
        fall();
        chk("R11 irq at 9th from start", byte_irq, 1'b1);
        @(negedge clk);
        rel_wait_cmd = 1; @(negedge clk); rel_wait_cmd = 0;
        stop_seen = 1; @(negedge clk); stop_seen = 0;
        @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule